// File: doc/BRIEF.md
# Call, Return and Branch Target Unit

This unit decides where an 8-bit microcontroller core fetches next. Each time `op_valid` is high and the unit is idle, it reads the operation code and the operand inputs. Jump-type operations register the new program counter one cycle later. The unit computes the page-local absolute target, the full 16-bit long target, the signed relative branch target and the data-pointer-plus-accumulator indirect target.

Calls, returns and single-byte push and pop operations use a synchronous single-port byte memory that lies outside the unit. The unit holds the stack pointer. It moves bytes one per clock and keeps `busy` high until the last access of a sequence is done. Instruction decode, condition evaluation and interrupt control sit elsewhere. The unit receives the condition result as `cond` and the instruction length as `ilen`.

Top module: `ctrl_flow_unit`

## Requirements
- R1: Operation code 1 (page jump) and code 2 (page call) target {bits 15..11 of cur_pc+2, opcode bits 7..5, opnd1}. The page is the one that holds the following instruction.
- R2: A page call pushes cur_pc+2. A long call pushes cur_pc+3. Each push increments SP and then writes: the low byte goes to SP_old+1 and the high byte to SP_old+2, modulo 256, and SP ends two higher.
- R3: Operation code 3 (long jump) and code 4 (long call) target {opnd1, opnd2}, with opnd1 as the high byte.
- R4: For operation code 5 with cond=1, the target is (cur_pc+L) plus the sign-extended displacement, modulo 2^16. L is 3 when ilen=3 and 2 otherwise. The displacement is opnd2 when L=3 and opnd1 otherwise, which gives a reach of -128..+127. With L=2, a displacement of FEh targets cur_pc itself.
- R5: For operation code 5 with cond=0, the target is cur_pc+L.
- R6: Operation code 6 targets dptr plus the zero-extended acc, modulo 2^16.
- R7: Operation code 7 (return) and code 8 (return from interrupt) read the high byte at SP and then the low byte at SP-1. SP ends two lower. The PC is loaded with the popped word. Code 8 also pulses `reti_ack` in the same cycle as `pc_load`.
- R8: Operation code 9 writes push_byte to SP+1 and leaves SP one higher. Operation code 10 reads at SP, returns the byte on pop_byte with `pop_valid`, and leaves SP one lower. Bytes therefore come back in last-in, first-out order.
- R9: While `busy` is high, `op_valid` is ignored: the PC, SP and memory take no effect from it. `busy` is low in any cycle where `pc_load` is high.
- R10: After reset the PC is 0000h, SP is 07h, and `busy`, `pc_load`, `pop_valid` and `reti_ack` are low.
- R11: Counted from the accepting clock edge, `pc_load` rises after 1 edge for codes 1, 3, 5 and 6, after 3 edges for calls, and after 4 edges for returns. `pop_valid` rises after 3 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_sel | input | 4 | Operation code (0 none, 1..10 as in requirements) |
| cur_pc | input | 16 | Address of the current instruction |
| opcode | input | 8 | First instruction byte |
| opnd1 | input | 8 | Second instruction byte |
| opnd2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cond | input | 1 | Branch condition result |
| ilen | input | 2 | Branch instruction length (2 or 3) |
| push_byte | input | 8 | Byte for a single push |
| mem_en | output | 1 | Stack memory access enable |
| mem_we | output | 1 | Stack memory write enable |
| mem_addr | output | 8 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, one cycle after address |
| busy | output | 1 | Stack sequence in progress |
| pc_out | output | 16 | Registered program counter |
| pc_load | output | 1 | One-cycle pulse: pc_out holds a new target |
| sp_out | output | 8 | Stack pointer |
| pop_byte | output | 8 | Byte from a single pop |
| pop_valid | output | 1 | One-cycle pulse: pop_byte is valid |
| reti_ack | output | 1 | Pulse at the end of a return from interrupt |

## Verification
The bench sweeps every branch displacement, with both lengths and both condition values, from a low PC and from a PC near FFFFh. A design that takes the displacement from the wrong byte, zero-extends it, or adds it to the current instruction address lands on the wrong target. Page targets are checked where cur_pc+2 crosses into the next 2K page; a unit that takes the page from cur_pc itself stays one page low. The bench fills the stack until SP reaches FEh and then calls, so the two pushes wrap through FFh to 00h. A swapped byte order or a post-increment stack shows up as wrong memory contents or a wrong return address. An operation offered while `busy` is high must leave the running call's target and SP untouched.

// File: rtl/cfu_pkg.sv
`timescale 1ns/1ps
package cfu_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_PJMP   = 4'd1,
        OP_PCALL  = 4'd2,
        OP_LJMP   = 4'd3,
        OP_LCALL  = 4'd4,
        OP_BRANCH = 4'd5,
        OP_JIND   = 4'd6,
        OP_RET    = 4'd7,
        OP_RETI   = 4'd8,
        OP_PUSH   = 4'd9,
        OP_POP    = 4'd10
    } cfu_op_e;

    typedef enum logic [3:0] {
        STK_IDLE,
        STK_WR_LO,
        STK_WR_HI,
        STK_WR_ONE,
        STK_RD_HI,
        STK_RD_LO,
        STK_RD_FIN,
        STK_RD_ONE,
        STK_RD_BYTE
    } stk_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_CALL,
        K_RET,
        K_RETI,
        K_PUSH,
        K_POP
    } pend_kind_e;

endpackage

// File: rtl/cfu_target_calc.sv
`timescale 1ns/1ps
module cfu_target_calc
    import cfu_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int OPC_FIELD_W = 3
) (
    input  cfu_op_e                 op,
    input  logic [2*BYTE_W-1:0]     cur_pc,
    input  logic [BYTE_W-1:0]       opcode,
    input  logic [BYTE_W-1:0]       opnd1,
    input  logic [BYTE_W-1:0]       opnd2,
    input  logic [BYTE_W-1:0]       acc,
    input  logic [2*BYTE_W-1:0]     dptr,
    input  logic                    cond,
    input  logic [1:0]              ilen,
    output logic [2*BYTE_W-1:0]     target,
    output logic [2*BYTE_W-1:0]     ret_addr
);
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int PAGE_W = BYTE_W + OPC_FIELD_W;

    logic [ADDR_W-1:0] pc_plus2;
    logic [ADDR_W-1:0] pc_plus3;
    logic [ADDR_W-1:0] page_tgt;
    logic [ADDR_W-1:0] long_tgt;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] ind_tgt;
    logic [BYTE_W-1:0] disp;
    logic              three_byte;

    always_comb begin
        pc_plus2   = cur_pc + ADDR_W'(2);
        pc_plus3   = cur_pc + ADDR_W'(3);
        three_byte = (ilen == 2'd3);
        page_tgt   = {pc_plus2[ADDR_W-1:PAGE_W],
                      opcode[BYTE_W-1 -: OPC_FIELD_W], opnd1};
        long_tgt   = {opnd1, opnd2};
        seq_addr   = three_byte ? pc_plus3 : pc_plus2;
        disp       = three_byte ? opnd2 : opnd1;
        rel_tgt    = seq_addr + {{BYTE_W{disp[BYTE_W-1]}}, disp};
        ind_tgt    = dptr + {{BYTE_W{1'b0}}, acc};

        unique case (op)
            OP_PJMP, OP_PCALL: target = page_tgt;
            OP_LJMP, OP_LCALL: target = long_tgt;
            OP_BRANCH:         target = cond ? rel_tgt : seq_addr;
            OP_JIND:           target = ind_tgt;
            default:           target = cur_pc;
        endcase

        ret_addr = (op == OP_LCALL) ? pc_plus3 : pc_plus2;
    end

endmodule

// File: rtl/cfu_stack_engine.sv
`timescale 1ns/1ps
module cfu_stack_engine
    import cfu_pkg::*;
#(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] SP_RESET = BYTE_W'(7)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_push2,
    input  logic                  start_pop2,
    input  logic                  start_push1,
    input  logic                  start_pop1,
    input  logic [2*BYTE_W-1:0]   push_word,
    input  logic [BYTE_W-1:0]     push_byte,
    output logic                  busy,
    output logic                  fin,
    output logic [2*BYTE_W-1:0]   pop_word,
    output logic [BYTE_W-1:0]     sp,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [BYTE_W-1:0]     mem_addr,
    output logic [BYTE_W-1:0]     mem_wdata,
    input  logic [BYTE_W-1:0]     mem_rdata
);
    localparam int ADDR_W = 2 * BYTE_W;

    typedef struct packed {
        stk_state_e        state;
        logic [BYTE_W-1:0] sp;
        logic [ADDR_W-1:0] word;
    } eng_t;

    eng_t r_q, r_d;
    logic [BYTE_W-1:0] sp_up;
    logic [BYTE_W-1:0] sp_dn;

    always_comb begin
        r_d       = r_q;
        sp_up     = r_q.sp + BYTE_W'(1);
        sp_dn     = r_q.sp - BYTE_W'(1);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.sp;
        mem_wdata = r_q.word[BYTE_W-1:0];
        fin       = 1'b0;

        unique case (r_q.state)
            STK_IDLE: begin
                if (start_push2) begin
                    r_d.word  = push_word;
                    r_d.state = STK_WR_LO;
                end else if (start_push1) begin
                    r_d.word  = {{BYTE_W{1'b0}}, push_byte};
                    r_d.state = STK_WR_ONE;
                end else if (start_pop2) begin
                    r_d.state = STK_RD_HI;
                end else if (start_pop1) begin
                    r_d.state = STK_RD_ONE;
                end
            end
            STK_WR_LO: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_up;
                mem_wdata = r_q.word[BYTE_W-1:0];
                r_d.sp    = sp_up;
                r_d.state = STK_WR_HI;
            end
            STK_WR_HI: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_up;
                mem_wdata = r_q.word[ADDR_W-1:BYTE_W];
                r_d.sp    = sp_up;
                fin       = 1'b1;
                r_d.state = STK_IDLE;
            end
            STK_WR_ONE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_up;
                mem_wdata = r_q.word[BYTE_W-1:0];
                r_d.sp    = sp_up;
                fin       = 1'b1;
                r_d.state = STK_IDLE;
            end
            STK_RD_HI: begin
                mem_en    = 1'b1;
                mem_addr  = r_q.sp;
                r_d.sp    = sp_dn;
                r_d.state = STK_RD_LO;
            end
            STK_RD_LO: begin
                mem_en    = 1'b1;
                mem_addr  = r_q.sp;
                r_d.sp    = sp_dn;
                r_d.word[ADDR_W-1:BYTE_W] = mem_rdata;
                r_d.state = STK_RD_FIN;
            end
            STK_RD_FIN: begin
                fin       = 1'b1;
                r_d.state = STK_IDLE;
            end
            STK_RD_ONE: begin
                mem_en    = 1'b1;
                mem_addr  = r_q.sp;
                r_d.sp    = sp_dn;
                r_d.state = STK_RD_BYTE;
            end
            STK_RD_BYTE: begin
                fin       = 1'b1;
                r_d.state = STK_IDLE;
            end
            default: r_d.state = STK_IDLE;
        endcase

        pop_word = {r_q.word[ADDR_W-1:BYTE_W], mem_rdata};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= STK_IDLE;
            r_q.sp    <= SP_RESET;
            r_q.word  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state != STK_IDLE);
    assign sp   = r_q.sp;

    // R2: each push write raises SP by one on the following edge
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (r_q.sp == BYTE_W'($past(r_q.sp) + BYTE_W'(1))));

    // R7: each pop read lowers SP by one on the following edge
    p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (r_q.sp == BYTE_W'($past(r_q.sp) - BYTE_W'(1))));

    // R9: SP holds while no sequence runs
    p_idle_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == STK_IDLE) |=> $stable(r_q.sp));

    // R2: a write never happens without the access enable
    p_we_with_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

// File: rtl/ctrl_flow_unit.sv
`timescale 1ns/1ps
module ctrl_flow_unit
    import cfu_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter int                OPC_FIELD_W = 3,
    parameter logic [BYTE_W-1:0] SP_RESET    = BYTE_W'(7)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [3:0]            op_sel,
    input  logic [2*BYTE_W-1:0]   cur_pc,
    input  logic [BYTE_W-1:0]     opcode,
    input  logic [BYTE_W-1:0]     opnd1,
    input  logic [BYTE_W-1:0]     opnd2,
    input  logic [BYTE_W-1:0]     acc,
    input  logic [2*BYTE_W-1:0]   dptr,
    input  logic                  cond,
    input  logic [1:0]            ilen,
    input  logic [BYTE_W-1:0]     push_byte,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [BYTE_W-1:0]     mem_addr,
    output logic [BYTE_W-1:0]     mem_wdata,
    input  logic [BYTE_W-1:0]     mem_rdata,
    output logic                  busy,
    output logic [2*BYTE_W-1:0]   pc_out,
    output logic                  pc_load,
    output logic [BYTE_W-1:0]     sp_out,
    output logic [BYTE_W-1:0]     pop_byte,
    output logic                  pop_valid,
    output logic                  reti_ack
);
    localparam int ADDR_W = 2 * BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              pc_load;
        logic [ADDR_W-1:0] pend_tgt;
        pend_kind_e        kind;
        logic [BYTE_W-1:0] pop_byte;
        logic              pop_valid;
        logic              reti_ack;
    } top_t;

    top_t r_q, r_d;

    cfu_op_e           op;
    logic              accept;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] ret_addr;
    logic              go_push2, go_pop2, go_push1, go_pop1;
    logic              eng_busy, eng_fin;
    logic [ADDR_W-1:0] eng_word;

    assign op = cfu_op_e'(op_sel);

    cfu_target_calc #(
        .BYTE_W      (BYTE_W),
        .OPC_FIELD_W (OPC_FIELD_W)
    ) u_calc (
        .op       (op),
        .cur_pc   (cur_pc),
        .opcode   (opcode),
        .opnd1    (opnd1),
        .opnd2    (opnd2),
        .acc      (acc),
        .dptr     (dptr),
        .cond     (cond),
        .ilen     (ilen),
        .target   (target),
        .ret_addr (ret_addr)
    );

    cfu_stack_engine #(
        .BYTE_W   (BYTE_W),
        .SP_RESET (SP_RESET)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_push2 (go_push2),
        .start_pop2  (go_pop2),
        .start_push1 (go_push1),
        .start_pop1  (go_pop1),
        .push_word   (ret_addr),
        .push_byte   (push_byte),
        .busy        (eng_busy),
        .fin         (eng_fin),
        .pop_word    (eng_word),
        .sp          (sp_out),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata)
    );

    always_comb begin
        r_d           = r_q;
        r_d.pc_load   = 1'b0;
        r_d.pop_valid = 1'b0;
        r_d.reti_ack  = 1'b0;
        go_push2      = 1'b0;
        go_pop2       = 1'b0;
        go_push1      = 1'b0;
        go_pop1       = 1'b0;
        accept        = op_valid && !eng_busy;

        if (accept) begin
            unique case (op)
                OP_PJMP, OP_LJMP, OP_BRANCH, OP_JIND: begin
                    r_d.pc      = target;
                    r_d.pc_load = 1'b1;
                end
                OP_PCALL, OP_LCALL: begin
                    r_d.pend_tgt = target;
                    r_d.kind     = K_CALL;
                    go_push2     = 1'b1;
                end
                OP_RET: begin
                    r_d.kind = K_RET;
                    go_pop2  = 1'b1;
                end
                OP_RETI: begin
                    r_d.kind = K_RETI;
                    go_pop2  = 1'b1;
                end
                OP_PUSH: begin
                    r_d.kind = K_PUSH;
                    go_push1 = 1'b1;
                end
                OP_POP: begin
                    r_d.kind = K_POP;
                    go_pop1  = 1'b1;
                end
                default: ;
            endcase
        end

        if (eng_fin) begin
            unique case (r_q.kind)
                K_CALL: begin
                    r_d.pc      = r_q.pend_tgt;
                    r_d.pc_load = 1'b1;
                end
                K_RET: begin
                    r_d.pc      = eng_word;
                    r_d.pc_load = 1'b1;
                end
                K_RETI: begin
                    r_d.pc       = eng_word;
                    r_d.pc_load  = 1'b1;
                    r_d.reti_ack = 1'b1;
                end
                K_POP: begin
                    r_d.pop_byte  = eng_word[BYTE_W-1:0];
                    r_d.pop_valid = 1'b1;
                end
                default: ;
            endcase
            r_d.kind = K_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.pc        <= '0;
            r_q.pc_load   <= 1'b0;
            r_q.pend_tgt  <= '0;
            r_q.kind      <= K_NONE;
            r_q.pop_byte  <= '0;
            r_q.pop_valid <= 1'b0;
            r_q.reti_ack  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = eng_busy;
    assign pc_out    = r_q.pc;
    assign pc_load   = r_q.pc_load;
    assign pop_byte  = r_q.pop_byte;
    assign pop_valid = r_q.pop_valid;
    assign reti_ack  = r_q.reti_ack;

    // R11: a jump-type operation lands one edge after acceptance
    p_jump_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op inside {OP_PJMP, OP_LJMP, OP_BRANCH, OP_JIND}))
        |=> (pc_load && (pc_out == $past(target))));

    // R11: a call loads its target exactly three edges after acceptance
    p_call_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op inside {OP_PCALL, OP_LCALL}))
        |=> (!pc_load && busy) ##1 (!pc_load && busy) ##1 pc_load);

    // R9: the PC is never announced while a sequence is still running
    p_load_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !busy);

    // R7: interrupt-return acknowledge coincides with the PC load
    p_reti_with_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reti_ack |-> pc_load);

    // R8: a single pop never moves the PC
    p_pop_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> !pc_load);

endmodule

// File: tb/ctrl_flow_unit_tb.sv
`timescale 1ns/1ps
module ctrl_flow_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_sel;
    logic [15:0] cur_pc;
    logic [7:0]  opcode, opnd1, opnd2, acc;
    logic [15:0] dptr;
    logic        cond;
    logic [1:0]  ilen;
    logic [7:0]  push_byte;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr, mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic [15:0] pc_out;
    logic        pc_load;
    logic [7:0]  sp_out;
    logic [7:0]  pop_byte;
    logic        pop_valid;
    logic        reti_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done_f = 1'b0;

    logic [7:0] mem [0:255];
    logic [7:0] pushed [0:255];
    logic [7:0] exp_sp;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    ctrl_flow_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .cur_pc(cur_pc), .opcode(opcode), .opnd1(opnd1), .opnd2(opnd2),
        .acc(acc), .dptr(dptr), .cond(cond), .ilen(ilen), .push_byte(push_byte),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .pc_out(pc_out), .pc_load(pc_load), .sp_out(sp_out),
        .pop_byte(pop_byte), .pop_valid(pop_valid), .reti_ack(reti_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [15:0] pc,
                         input logic [7:0] opc, input logic [7:0] o1,
                         input logic [7:0] o2, input logic [7:0] a,
                         input logic [15:0] dp, input logic c,
                         input logic [1:0] il, input logic [7:0] pb);
        @(negedge clk);
        op_sel = op; cur_pc = pc; opcode = opc; opnd1 = o1; opnd2 = o2;
        acc = a; dptr = dp; cond = c; ilen = il; push_byte = pb;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic logic [15:0] f_page(input logic [15:0] pc, input logic [7:0] opc,
                                           input logic [7:0] o1);
        logic [15:0] nx;
        nx = pc + 16'd2;
        return (nx & 16'hF800) | (16'(opc >> 5) << 8) | 16'(o1);
    endfunction

    function automatic logic [15:0] f_rel(input logic [15:0] pc, input int il,
                                          input int d, input logic c);
        int seq;
        int t;
        seq = int'(pc) + il;
        t   = c ? seq + ((d > 127) ? d - 256 : d) : seq;
        return 16'(t & 32'hFFFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_f) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pcs [0:4];
        logic [15:0] dps [0:2];
        logic [15:0] bpc [0:1];
        logic [15:0] e;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst_n = 1'b0; op_valid = 1'b0; op_sel = 4'd0; cur_pc = '0; opcode = '0;
        opnd1 = '0; opnd2 = '0; acc = '0; dptr = '0; cond = 1'b0; ilen = 2'd2;
        push_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 pc", 32'(pc_out), 32'h0000);
        chk("R10 sp", 32'(sp_out), 32'h07);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 pc_load", 32'(pc_load), 0);
        chk("R10 pop_valid", 32'(pop_valid), 0);
        chk("R10 reti_ack", 32'(reti_ack), 0);

        // R1 page jump sweep, including page crossing at cur_pc+2
        pcs[0] = 16'h0000; pcs[1] = 16'h07FE; pcs[2] = 16'h07FD;
        pcs[3] = 16'h1234; pcs[4] = 16'hFFFE;
        for (int p = 0; p < 5; p++) begin
            for (int h = 0; h < 8; h++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] o1v;
                    logic [7:0] opc;
                    o1v = (k == 0) ? 8'h00 : ((k == 1) ? 8'h5A : 8'hFF);
                    opc = {3'(h), 5'b00001};
                    issue(4'd1, pcs[p], opc, o1v, 8'h99, 8'h00, 16'h0, 1'b0, 2'd2, 8'h0);
                    chk("R1 page jump load", 32'(pc_load), 1);
                    chk("R1 page jump target", 32'(pc_out), 32'(f_page(pcs[p], opc, o1v)));
                end
            end
        end

        // R3 long jump
        issue(4'd3, 16'h0123, 8'h02, 8'h12, 8'h34, 8'h0, 16'h0, 1'b0, 2'd3, 8'h0);
        chk("R3 long jump", 32'(pc_out), 32'h1234);
        issue(4'd3, 16'hFFFF, 8'h02, 8'hFE, 8'h01, 8'h0, 16'h0, 1'b0, 2'd3, 8'h0);
        chk("R3 long jump high first", 32'(pc_out), 32'hFE01);

        // R4 / R5 branch sweep over every displacement, length and condition
        bpc[0] = 16'h0100; bpc[1] = 16'hFFF0;
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 256; d++) begin
                for (int il = 2; il <= 3; il++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [7:0] o1v, o2v;
                        o1v = (il == 3) ? (8'(d) ^ 8'h3C) : 8'(d);
                        o2v = (il == 3) ? 8'(d) : (8'(d) ^ 8'hC3);
                        issue(4'd5, bpc[p], 8'h70, o1v, o2v, 8'h0, 16'h0, 1'(c), 2'(il), 8'h0);
                        e = f_rel(bpc[p], il, d, 1'(c));
                        if (c == 1) chk("R4 taken branch", 32'(pc_out), 32'(e));
                        else        chk("R5 not-taken branch", 32'(pc_out), 32'(e));
                    end
                end
            end
        end
        issue(4'd5, 16'h0200, 8'h80, 8'hFE, 8'h00, 8'h0, 16'h0, 1'b1, 2'd2, 8'h0);
        chk("R4 self-loop displacement", 32'(pc_out), 32'h0200);

        // R6 indirect jump
        dps[0] = 16'h0000; dps[1] = 16'hFF80; dps[2] = 16'h1234;
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 256; a += 17) begin
                issue(4'd6, 16'h5555, 8'h73, 8'h00, 8'h00, 8'(a), dps[p], 1'b0, 2'd2, 8'h0);
                chk("R6 indirect jump", 32'(pc_out), 32'((dps[p] + 16'(a)) & 16'hFFFF));
            end
        end

        // R2 page call from 0123h to 0345h with SP=07h
        issue(4'd2, 16'h0123, 8'h71, 8'h45, 8'h00, 8'h0, 16'h0, 1'b0, 2'd2, 8'h0);
        chk("R9 busy during call", 32'(busy), 1);
        chk("R11 no early load", 32'(pc_load), 0);
        @(negedge clk);
        chk("R11 no early load 2", 32'(pc_load), 0);
        @(negedge clk);
        chk("R11 call load", 32'(pc_load), 1);
        chk("R2 call target", 32'(pc_out), 32'h0345);
        chk("R2 sp after call", 32'(sp_out), 32'h09);
        chk("R2 low byte first", 32'(mem[8'h08]), 32'h25);
        chk("R2 high byte second", 32'(mem[8'h09]), 32'h01);

        // R7 return
        issue(4'd7, 16'h0345, 8'h22, 8'h00, 8'h00, 8'h0, 16'h0, 1'b0, 2'd2, 8'h0);
        @(negedge clk);
        @(negedge clk);
        chk("R11 no early ret load", 32'(pc_load), 0);
        @(negedge clk);
        chk("R11 ret load", 32'(pc_load), 1);
        chk("R7 return address", 32'(pc_out), 32'h0125);
        chk("R7 sp after return", 32'(sp_out), 32'h07);
        chk("R7 plain return no ack", 32'(reti_ack), 0);

        // R3 long call, then R7 return from interrupt
        issue(4'd4, 16'h4000, 8'h12, 8'hBE, 8'hEF, 8'h0, 16'h0, 1'b0, 2'd3, 8'h0);
        @(negedge clk);
        @(negedge clk);
        chk("R3 long call target", 32'(pc_out), 32'hBEEF);
        chk("R3 long call ret lo", 32'(mem[8'h08]), 32'h03);
        chk("R3 long call ret hi", 32'(mem[8'h09]), 32'h40);
        issue(4'd8, 16'hBEEF, 8'h32, 8'h00, 8'h00, 8'h0, 16'h0, 1'b0, 2'd2, 8'h0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R7 reti load", 32'(pc_load), 1);
        chk("R7 reti ack", 32'(reti_ack), 1);
        chk("R7 reti address", 32'(pc_out), 32'h4003);
        chk("R7 reti sp", 32'(sp_out), 32'h07);

        // R9 operation offered while busy is ignored
        issue(4'd4, 16'h2000, 8'h12, 8'h3A, 8'h5C, 8'h0, 16'h0, 1'b0, 2'd3, 8'h0);
        op_sel = 4'd1; cur_pc = 16'h0000; opcode = 8'hE1; opnd1 = 8'h77; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 ignored op no load", 32'(pc_load), 0);
        @(negedge clk);
        chk("R9 call completes", 32'(pc_load), 1);
        chk("R9 call target kept", 32'(pc_out), 32'h3A5C);
        chk("R9 sp kept", 32'(sp_out), 32'h09);
        chk("R9 return lo kept", 32'(mem[8'h08]), 32'h03);
        chk("R9 return hi kept", 32'(mem[8'h09]), 32'h20);
        issue(4'd7, 16'h3A5C, 8'h22, 8'h00, 8'h00, 8'h0, 16'h0, 1'b0, 2'd2, 8'h0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R7 return after ignore", 32'(pc_out), 32'h2003);

        // R8 single pushes until SP reaches FEh
        exp_sp = 8'h07;
        for (int i = 0; i < 247; i++) begin
            logic [7:0] pb;
            pb = 8'(i * 7 + 3);
            pushed[i] = pb;
            issue(4'd9, 16'h0, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, 1'b0, 2'd2, pb);
            @(negedge clk);
            exp_sp = exp_sp + 8'd1;
            chk("R8 push sp", 32'(sp_out), 32'(exp_sp));
            chk("R8 push data", 32'(mem[exp_sp]), 32'(pb));
            chk("R8 push done", 32'(busy), 0);
        end

        // R2 call with SP wrapping through FFh to 00h
        issue(4'd4, 16'h7FF0, 8'h12, 8'h12, 8'h34, 8'h0, 16'h0, 1'b0, 2'd3, 8'h0);
        @(negedge clk);
        @(negedge clk);
        chk("R2 wrap sp", 32'(sp_out), 32'h00);
        chk("R2 wrap lo at FF", 32'(mem[8'hFF]), 32'hF3);
        chk("R2 wrap hi at 00", 32'(mem[8'h00]), 32'h7F);
        issue(4'd7, 16'h1234, 8'h22, 8'h00, 8'h00, 8'h0, 16'h0, 1'b0, 2'd2, 8'h0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R7 wrap return", 32'(pc_out), 32'h7FF3);
        chk("R7 wrap sp", 32'(sp_out), 32'hFE);

        // R8 pops return bytes last in, first out
        for (int i = 246; i >= 0; i--) begin
            issue(4'd10, 16'h0, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, 1'b0, 2'd2, 8'h0);
            @(negedge clk);
            chk("R8 pop not early", 32'(pop_valid), 0);
            @(negedge clk);
            exp_sp = exp_sp - 8'd1;
            chk("R8 pop valid", 32'(pop_valid), 1);
            chk("R8 pop data", 32'(pop_byte), 32'(pushed[i]));
            chk("R8 pop sp", 32'(sp_out), 32'(exp_sp));
        end

        done_f = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule